// File: doc/BRIEF.md
# Error-Count Interrupt Pacer

This block sits between a memory controller's error detectors and an interrupt unit and thins out recoverable-error interrupts. It holds four identical channels. Each channel has an error-event input, a 16-bit down-counter and a mode bit. When the mode bit is clear, each error lowers the counter by one, and only the step from 1 to 0 raises an interrupt. When the mode bit is set, counting is bypassed and every error raises an interrupt.

Software programs the channels over a plain 64-bit register bus. Only privileged requests are accepted. Each channel sits at its own address, spaced one 4 KiB page apart. A read returns its data one cycle after the request. Each interrupt output is a one-cycle pulse that appears on the cycle after the qualifying error event.

Top module: `err_irq_pacer`

## Requirements
- R1: After synchronous reset every channel reads count 0 and mode 0, every `irq` bit is low and `bus_rvalid` is low.
- R2: A channel word carries the count in bits 15:0 and the mode bit in bit 16. Bits 63:17 always read as zero, and writes to those bits have no effect.
- R3: Channel i answers at address 0x84_0000_0C10 + i*0x1000, for i = 0..3. A read request in one cycle gives `bus_rvalid` high for exactly the next cycle, with `bus_rdata` holding the channel value as it was before that clock edge. A write takes effect at the clock edge where it is presented.
- R4: With the mode bit set, every error event on a channel gives an `irq` pulse on that channel in the following cycle, and the count does not change.
- R5: With the mode bit clear and the count non-zero, each error event lowers the count by exactly one.
- R6: With the mode bit clear, an `irq` pulse of one cycle follows only the error event that takes the count from 1 to 0. Decrements from larger values raise no interrupt.
- R7: With the mode bit clear and the count at 0, an error event leaves the count at 0 and raises no interrupt.
- R8: When a write and an error event hit the same channel in the same cycle, the written value is stored and the event is not counted. An interrupt is still raised if the mode bit was set before the write.
- R9: When `bus_priv` is low, reads return zero and writes change no channel.
- R10: An address that matches none of the four channels returns zero on a read and changes nothing on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 40 | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_priv | input | 1 | Requester is in privileged mode |
| bus_rvalid | output | 1 | Read data valid (cycle after a read request) |
| bus_rdata | output | 64 | Read data |
| err_ev | input | 4 | Per-channel recoverable-error event |
| irq | output | 4 | Per-channel interrupt pulse |

## Verification
The counting path is swept per channel with starting counts 0 to 4, each followed by more errors than the count holds. This separates a correct 1-to-0 trigger from an early trigger, a late trigger, a trigger that fires on every step, and a counter that wraps below zero. Every 4-bit pattern of simultaneous error events is applied to channels with mixed modes and counts. This shows whether the channels are truly independent and whether the two modes are kept apart. Writes that land in the same cycle as an error are tried with the mode bit both set and clear. Privilege, reserved bits and unmapped or misaligned addresses are probed with writes that are then read back, so that a leaked write shows up.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;

    localparam int DATA_W    = 64;
    localparam int CNT_W     = 16;
    localparam int MODE_BIT  = CNT_W;
    localparam int USED_W    = CNT_W + 1;
    localparam int RSVD_W    = DATA_W - USED_W;

    typedef struct packed {
        logic             every;
        logic [CNT_W-1:0] cnt;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    function automatic logic [DATA_W-1:0] cfg_to_word(input chan_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_W-1:0] = c.cnt;
        w[MODE_BIT]  = c.every;
        return w;
    endfunction

    function automatic chan_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        chan_cfg_t c;
        c.cnt   = w[CNT_W-1:0];
        c.every = w[MODE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pacer_addr_dec.sv
module pacer_addr_dec
    import irq_pacer_pkg::*;
#(
    parameter int                NUM_CH = 4,
    parameter int                ADDR_W = 40,
    parameter logic [ADDR_W-1:0] BASE   = 40'h84_0000_0C10,
    parameter int                STRIDE = 4096
) (
    input  logic              en,
    input  logic              we,
    input  logic              priv,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [NUM_CH-1:0] sel
);

    logic [NUM_CH-1:0] match;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_match
        localparam logic [ADDR_W-1:0] CH_ADDR =
            BASE + ADDR_W'(i) * ADDR_W'(STRIDE);
        assign match[i] = (addr == CH_ADDR);
    end

    always_comb begin
        kind = ACC_NONE;
        if (en) begin
            kind = we ? ACC_WRITE : ACC_READ;
        end
        sel = (en && priv) ? match : '0;
    end

endmodule

// File: rtl/pacer_channel.sv
module pacer_channel
    import irq_pacer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  chan_cfg_t wr_cfg,
    input  logic      err,
    output chan_cfg_t cfg,
    output logic      irq
);

    chan_cfg_t cfg_q;
    chan_cfg_t cfg_d;
    logic      irq_d;
    logic      at_one;
    logic      at_zero;

    assign at_one  = (cfg_q.cnt == CNT_W'(1));
    assign at_zero = (cfg_q.cnt == '0);

    always_comb begin
        cfg_d = cfg_q;
        irq_d = 1'b0;
        if (err) begin
            if (cfg_q.every) begin
                irq_d = 1'b1;
            end else if (!wr && !at_zero) begin
                cfg_d.cnt = cfg_q.cnt - CNT_W'(1);
                irq_d     = at_one;
            end
        end
        if (wr) begin
            cfg_d = wr_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            irq   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            irq   <= irq_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pacer_rd_path.sv
module pacer_rd_path
    import irq_pacer_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  acc_kind_t              kind,
    input  logic [NUM_CH-1:0]      sel,
    input  chan_cfg_t [NUM_CH-1:0] cfgs,
    output logic                   rvalid,
    output logic [DATA_W-1:0]      rdata
);

    logic [DATA_W-1:0] mux;

    always_comb begin
        mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) begin
                mux = mux | cfg_to_word(cfgs[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= (kind == ACC_READ);
            rdata  <= (kind == ACC_READ) ? mux : '0;
        end
    end

endmodule

// File: rtl/err_irq_pacer.sv
module err_irq_pacer
    import irq_pacer_pkg::*;
#(
    parameter int                NUM_CH = 4,
    parameter int                ADDR_W = 40,
    parameter logic [ADDR_W-1:0] BASE   = 40'h84_0000_0C10,
    parameter int                STRIDE = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] err_ev,
    output logic [NUM_CH-1:0] irq
);

    acc_kind_t                kind;
    logic [NUM_CH-1:0]        sel;
    logic [NUM_CH-1:0]        ch_wr;
    chan_cfg_t [NUM_CH-1:0]   cfgs;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
    logic [NUM_CH-1:0]        ch_every;
    chan_cfg_t                wr_cfg;

    assign wr_cfg = word_to_cfg(bus_wdata);

    pacer_addr_dec #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
    ) u_dec (
        .en(bus_en), .we(bus_we), .priv(bus_priv), .addr(bus_addr),
        .kind(kind), .sel(sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_wr[i]    = sel[i] && (kind == ACC_WRITE);
        assign ch_cnt[i]   = cfgs[i].cnt;
        assign ch_every[i] = cfgs[i].every;

        pacer_channel u_ch (
            .clk(clk), .rst(rst),
            .wr(ch_wr[i]), .wr_cfg(wr_cfg),
            .err(err_ev[i]),
            .cfg(cfgs[i]), .irq(irq[i])
        );
    end

    pacer_rd_path #(.NUM_CH(NUM_CH)) u_rd (
        .clk(clk), .rst(rst), .kind(kind), .sel(sel), .cfgs(cfgs),
        .rvalid(bus_rvalid), .rdata(bus_rdata)
    );

endmodule

// File: rtl/err_irq_pacer_chk.sv
module err_irq_pacer_chk
    import irq_pacer_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_en,
    input logic                         bus_we,
    input logic                         bus_priv,
    input logic                         bus_rvalid,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_CH-1:0]            err_ev,
    input logic [NUM_CH-1:0]            irq,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0]            ch_every,
    input logic [NUM_CH-1:0]            ch_wr
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> (bus_rdata[DATA_W-1:USED_W] == '0));

    assert_rvalid_follows_read_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we) |=> bus_rvalid);

    assert_unpriv_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && !bus_priv) |=> (bus_rdata == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_irq_needs_event_R6: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> $past(err_ev[i]));

        assert_every_mode_fires_R4: assert property (@(posedge clk) disable iff (rst)
            (err_ev[i] && ch_every[i]) |=> irq[i]);

        assert_every_mode_holds_R4: assert property (@(posedge clk) disable iff (rst)
            (ch_every[i] && !ch_wr[i]) |=> $stable(ch_cnt[i]));

        assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
            (!ch_wr[i] && !ch_every[i] && ch_cnt[i] == '0) |=>
                (ch_cnt[i] == '0 && !irq[i]));

        assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
            (!ch_wr[i] && !ch_every[i] && err_ev[i] && ch_cnt[i] != '0) |=>
                (ch_cnt[i] == $past(ch_cnt[i]) - CNT_W'(1)));
    end

endmodule

bind err_irq_pacer err_irq_pacer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_priv(bus_priv), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .err_ev(err_ev), .irq(irq), .ch_cnt(ch_cnt), .ch_every(ch_every),
    .ch_wr(ch_wr)
);

// File: tb/sim_err_irq_pacer.sv
module sim_err_irq_pacer;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam logic [39:0] BASE = 40'h84_0000_0C10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en, bus_we, bus_priv;
    logic [39:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_rvalid;
    logic [63:0] bus_rdata;
    logic [3:0]  err_ev;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    int m_cnt  [NCH];
    bit m_every[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    err_irq_pacer u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .err_ev(err_ev), .irq(irq)
    );

    function automatic logic [39:0] ch_addr(input int i);
        return BASE + 40'(i) * 40'd4096;
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample at the following negedge.
    task automatic cyc(input logic en, input logic we, input logic [39:0] addr,
                       input logic [63:0] wd, input logic pv, input logic [3:0] err,
                       input string tag);
        int  hit;
        logic [3:0]  e_irq;
        logic [63:0] e_rd;
        bus_en = en; bus_we = we; bus_addr = addr; bus_wdata = wd;
        bus_priv = pv; err_ev = err;
        hit = -1;
        for (int i = 0; i < NCH; i++) if (addr == ch_addr(i)) hit = i;
        e_rd = '0;
        if (en && !we && pv && hit >= 0)
            e_rd = {47'd0, m_every[hit], 16'(m_cnt[hit])};
        for (int i = 0; i < NCH; i++) begin
            bit w;
            w = en && we && pv && (hit == i);
            e_irq[i] = err[i] && (m_every[i] || (!w && m_cnt[i] == 1));
            if (w) begin
                m_cnt[i]   = int'(wd[15:0]);
                m_every[i] = wd[16];
            end else if (err[i] && !m_every[i] && m_cnt[i] > 0) begin
                m_cnt[i]--;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check64({tag, " irq"}, {60'd0, irq}, {60'd0, e_irq});
        if (en && !we) begin
            check64({tag, " rvalid"}, {63'd0, bus_rvalid}, 64'd1);
            check64({tag, " rdata"}, bus_rdata, e_rd);
        end
        bus_en = 0; bus_we = 0; err_ev = '0; bus_priv = 0;
    endtask

    task automatic wr(input int ch, input logic [63:0] d, input string tag);
        cyc(1, 1, ch_addr(ch), d, 1, 4'h0, tag);
    endtask

    task automatic rd(input int ch, input string tag);
        cyc(1, 0, ch_addr(ch), 64'd0, 1, 4'h0, tag);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst = 1; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        bus_priv = 0; err_ev = '0;
        for (int i = 0; i < NCH; i++) begin m_cnt[i] = 0; m_every[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check64("R1 irq", {60'd0, irq}, 64'd0);
        check64("R1 rvalid", {63'd0, bus_rvalid}, 64'd0);
        for (int i = 0; i < NCH; i++) rd(i, "R1 reset read");

        // R2: reserved bits ignored on write, read as zero
        wr(0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 write ones");
        rd(0, "R2 readback");
        wr(0, 64'hA5A5_0000_0000_0000, "R2 write reserved only");
        rd(0, "R2 readback reserved");

        // R3: address map, distinct value per channel
        for (int i = 0; i < NCH; i++) wr(i, 64'(16'h0100 + i) | (64'(i & 1) << 16), "R3 write");
        for (int i = 0; i < NCH; i++) rd(i, "R3 read");
        for (int i = 0; i < NCH; i++) wr(i, 64'd0, "R3 clear");

        // R5 R6 R7: count sweep per channel, overrun past zero
        for (int ch = 0; ch < NCH; ch++) begin
            for (int n = 0; n < 5; n++) begin
                wr(ch, 64'(n), "R5 load");
                for (int k = 0; k < n + 2; k++)
                    cyc(1, 0, ch_addr(ch), 64'd0, 1, 4'(1 << ch), "R6 R7 count step");
                rd(ch, "R7 after overrun");
            end
        end

        // R4: every-error mode with a held count
        wr(2, 64'h1_0003, "R4 load");
        for (int k = 0; k < 4; k++)
            cyc(1, 0, ch_addr(2), 64'd0, 1, 4'b0100, "R4 every event");
        rd(2, "R4 count held");

        // Multi-channel independence: every error mask
        wr(0, 64'h0_0009, "R5 mix"); wr(1, 64'h1_0002, "R4 mix");
        wr(2, 64'h0_0001, "R6 mix"); wr(3, 64'h0_0000, "R7 mix");
        for (int m = 0; m < 16; m++) begin
            cyc(0, 0, 40'd0, 64'd0, 0, 4'(m), "R6 mask sweep");
            if (m % 4 == 3) wr(2, 64'h0_0001, "R6 reload");
        end
        for (int i = 0; i < NCH; i++) rd(i, "R5 mask sweep read");

        // R8: write colliding with an error
        wr(1, 64'h0_0001, "R8 prep");
        cyc(1, 1, ch_addr(1), 64'h0_0005, 1, 4'b0010, "R8 collide count");
        rd(1, "R8 written value wins");
        wr(1, 64'h1_0007, "R8 prep mode");
        cyc(1, 1, ch_addr(1), 64'h0_0004, 1, 4'b0010, "R8 collide mode");
        rd(1, "R8 readback");

        // R9: non-privileged access
        wr(3, 64'h0_0042, "R9 prep");
        cyc(1, 1, ch_addr(3), 64'h1_1234, 0, 4'h0, "R9 unpriv write");
        cyc(1, 0, ch_addr(3), 64'd0, 0, 4'h0, "R9 unpriv read");
        rd(3, "R9 value kept");

        // R10: unmapped addresses
        cyc(1, 1, BASE - 40'd8, 64'h0_7777, 1, 4'h0, "R10 below");
        cyc(1, 1, ch_addr(4), 64'h0_7777, 1, 4'h0, "R10 past end");
        cyc(1, 1, BASE + 40'd8, 64'h0_7777, 1, 4'h0, "R10 misaligned");
        cyc(1, 0, ch_addr(4), 64'd0, 1, 4'h0, "R10 read unmapped");
        cyc(1, 0, BASE + 40'd4, 64'd0, 1, 4'h0, "R10 read misaligned");
        for (int i = 0; i < NCH; i++) rd(i, "R10 nothing changed");

        finish_up();
    end

endmodule